// File: doc/BRIEF.md
# Multidrop Receive Address Gate

This block sits between a serial receiver and its receive FIFO. For every character that the receiver reports, it decides whether the character is written into the FIFO. The decision rests on a lock state. Software sets this state with a lock command and clears it with an unlock command. On a multidrop line, where one master addresses many stations, the gate can also clear the lock by itself when an address character arrives. The receiver marks an address character with a marker bit. One of three recognition policies governs this: no self-unlock at all, unlock on any address character, or unlock only on an address character equal to the station address.

A fourth setting turns the gate into a control-character watcher. In that setting the marker bit has no effect on the lock. The gate raises an interrupt pulse whenever a control code of the selected code set arrives. In every setting, a second interrupt pulses when a character equals either of two programmable match characters. When a character is thrown away while an earlier discarded character is still unacknowledged, the gate pulses a lost-character flag. All outputs are registered and appear one cycle after the character strobe.

Top module: `rx_addr_gate`

## Requirements
- R1: After a synchronous reset, `locked` is 1 and `fifo_wr`, `lost_pulse`, `ctrl_irq` and `match_irq` are 0.
- R2: A character presented with `rx_valid` while the effective lock is open produces `fifo_wr`=1 with `fifo_data` equal to the character on the next cycle. While the FIFO is locked and no self-unlock applies, `fifo_wr` stays 0.
- R3: `cmd_lock` sets and `cmd_unlock` clears `locked`, both visible the next cycle. When both are asserted together, lock wins.
- R4: With `cfg_mode`=2'b10 (matching address), a character with `rx_mark`=1 equal to `cfg_station` clears the lock and is itself written in that cycle. A marked character that does not match leaves the lock unchanged.
- R5: With `cfg_mode`=2'b01 (any address), every character with `rx_mark`=1 clears the lock and is itself written.
- R6: With `cfg_mode`=2'b00 (manual), received characters never change `locked`.
- R7: With `cfg_mode`=2'b11 (control watch), `rx_mark` never changes `locked`. `ctrl_irq` pulses for codes 0x00..0x1F and 0x7F when `cfg_ebcdic`=0, and for codes 0x00..0x3F when `cfg_ebcdic`=1. `ctrl_irq` is never raised in the other modes.
- R8: `match_irq` pulses the cycle after any received character equal to `cfg_match0` or `cfg_match1`, in every mode and regardless of the lock.
- R9: When a software command coincides with a self-unlocking address character, the command alone sets the next lock state. The character is judged by the lock state held before that cycle.
- R10: `lost_pulse` pulses the cycle after a discarded character when a previous discard is still pending and `lost_ack` is low in that cycle.
- R11: `lost_ack` clears the pending-discard state. A discard in the same cycle as the acknowledge leaves a new pending discard, but it does not pulse `lost_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_mark | input | 1 | Address/control marker bit of the character |
| cfg_mode | input | 2 | 00 manual, 01 any address, 10 matching address, 11 control watch |
| cfg_ebcdic | input | 1 | Control code set: 0 ASCII, 1 EBCDIC |
| cfg_station | input | 8 | Station address |
| cfg_match0 | input | 8 | First match character |
| cfg_match1 | input | 8 | Second match character |
| cmd_unlock | input | 1 | Software unlock command pulse |
| cmd_lock | input | 1 | Software lock command pulse |
| lost_ack | input | 1 | Acknowledge of discarded characters |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 8 | Character to write |
| locked | output | 1 | Current lock state |
| lost_pulse | output | 1 | Lost-character pulse |
| ctrl_irq | output | 1 | Control-character interrupt pulse |
| match_irq | output | 1 | Match-character interrupt pulse |

## Verification
The bench sweeps every byte value, with the marker bit both low and high, from both a locked and an open start, in all four modes. It compares each result against a model built arithmetically from the requirements. The boundaries of the two control code sets come up in this sweep: 0x1F/0x20, 0x3F/0x40 and 0x7E/0x7F/0x80. A classifier with an off-by-one limit would raise or miss `ctrl_irq` on exactly one of those codes. Directed sequences cover a command that lands in the same cycle as a matching address character. A design that let the self-unlock win there would write the character or leave the FIFO open. Further sequences cover an acknowledge that coincides with a discard. A design that ordered the clear and the set of the pending state the wrong way would either pulse `lost_pulse` or lose the new pending discard.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {
    MD_MANUAL = 2'b00,
    MD_ANY    = 2'b01,
    MD_MATCH  = 2'b10,
    MD_CTRL   = 2'b11
  } gate_mode_e;

  localparam int unsigned ASCII_CTRL_LIM = 32;
  localparam int unsigned ASCII_DEL      = 127;
  localparam int unsigned EBCDIC_CTRL_LIM = 64;
endpackage

// File: rtl/rxg_classify.sv
module rxg_classify
  import rxg_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned N_MATCH = 2
) (
  input  logic                  valid,
  input  logic [DW-1:0]         data,
  input  logic                  mark,
  input  gate_mode_e            mode,
  input  logic                  ebcdic,
  input  logic [DW-1:0]         station,
  input  logic [N_MATCH*DW-1:0] match_chars,
  output logic                  unlock_req,
  output logic                  ctrl_evt,
  output logic                  match_evt
);
  localparam logic [DW-1:0] ASCII_LIM = DW'(ASCII_CTRL_LIM);
  localparam logic [DW-1:0] DEL_CODE  = DW'(ASCII_DEL);
  localparam logic [DW-1:0] EBC_LIM   = DW'(EBCDIC_CTRL_LIM);

  logic [N_MATCH-1:0] hit_vec;
  logic               addr_char;
  logic               is_ctrl_code;

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    assign hit_vec[g] = (data == match_chars[g*DW +: DW]);
  end

  always_comb begin
    addr_char  = valid && mark && (mode != MD_CTRL);
    unlock_req = 1'b0;
    unique case (mode)
      MD_ANY:   unlock_req = addr_char;
      MD_MATCH: unlock_req = addr_char && (data == station);
      default:  unlock_req = 1'b0;
    endcase
  end

  always_comb begin
    if (ebcdic) is_ctrl_code = (data < EBC_LIM);
    else        is_ctrl_code = (data < ASCII_LIM) || (data == DEL_CODE);
    ctrl_evt  = valid && (mode == MD_CTRL) && is_ctrl_code;
    match_evt = valid && (|hit_vec);
  end
endmodule

// File: rtl/rxg_lock_ctl.sv
module rxg_lock_ctl #(
  parameter bit LOCK_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic unlock_req,
  input  logic cmd_unlock,
  input  logic cmd_lock,
  input  logic lost_ack,
  output logic write_now,
  output logic lost_now,
  output logic lock_q
);
  logic pend_q;
  logic cmd_any;
  logic self_open;
  logic discard;

  always_comb begin
    cmd_any   = cmd_unlock || cmd_lock;
    self_open = unlock_req && !cmd_any;
    write_now = valid && (!lock_q || self_open);
    discard   = valid && !write_now;
    lost_now  = discard && pend_q && !lost_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= LOCK_AT_RESET;
      pend_q <= 1'b0;
    end else begin
      if (cmd_lock)        lock_q <= 1'b1;
      else if (cmd_unlock) lock_q <= 1'b0;
      else if (self_open)  lock_q <= 1'b0;
      pend_q <= discard || (pend_q && !lost_ack);
    end
  end

  p_cmd_lock_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_lock |=> lock_q);
  p_cmd_unlock_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_unlock && !cmd_lock) |=> !lock_q);
  p_hold_no_req_r6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_lock && !cmd_unlock && !unlock_req) |=> $stable(lock_q));
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (lost_ack && !valid) |=> !pend_q);
endmodule

// File: rtl/rx_addr_gate.sv
module rx_addr_gate
  import rxg_pkg::*;
#(
  parameter int unsigned DW            = 8,
  parameter bit          LOCK_AT_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_mark,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_ebcdic,
  input  logic [DW-1:0] cfg_station,
  input  logic [DW-1:0] cfg_match0,
  input  logic [DW-1:0] cfg_match1,
  input  logic          cmd_unlock,
  input  logic          cmd_lock,
  input  logic          lost_ack,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          locked,
  output logic          lost_pulse,
  output logic          ctrl_irq,
  output logic          match_irq
);
  localparam int unsigned N_MATCH = 2;

  gate_mode_e mode;
  logic       unlock_req;
  logic       ctrl_evt;
  logic       match_evt;
  logic       write_now;
  logic       lost_now;

  assign mode = gate_mode_e'(cfg_mode);

  rxg_classify #(.DW(DW), .N_MATCH(N_MATCH)) u_classify (
    .valid       (rx_valid),
    .data        (rx_data),
    .mark        (rx_mark),
    .mode        (mode),
    .ebcdic      (cfg_ebcdic),
    .station     (cfg_station),
    .match_chars ({cfg_match1, cfg_match0}),
    .unlock_req  (unlock_req),
    .ctrl_evt    (ctrl_evt),
    .match_evt   (match_evt)
  );

  rxg_lock_ctl #(.LOCK_AT_RESET(LOCK_AT_RESET)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .valid      (rx_valid),
    .unlock_req (unlock_req),
    .cmd_unlock (cmd_unlock),
    .cmd_lock   (cmd_lock),
    .lost_ack   (lost_ack),
    .write_now  (write_now),
    .lost_now   (lost_now),
    .lock_q     (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_data  <= '0;
      lost_pulse <= 1'b0;
      ctrl_irq   <= 1'b0;
      match_irq  <= 1'b0;
    end else begin
      fifo_wr    <= write_now;
      lost_pulse <= lost_now;
      ctrl_irq   <= ctrl_evt;
      match_irq  <= match_evt;
      if (write_now) fifo_data <= rx_data;
    end
  end

  p_wr_needs_char_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(rx_valid));
  p_locked_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && locked && !rx_mark) |=> !fifo_wr);
  p_ctrl_mode_only_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_irq |-> ($past(cfg_mode) == 2'b11));
  p_match_needs_char_r8: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> $past(rx_valid));
  p_lost_not_written_r10: assert property (@(posedge clk) disable iff (rst)
    lost_pulse |-> !fifo_wr);
endmodule

// File: tb/test_rx_addr_gate.sv
module test_rx_addr_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] ST = 8'h5A;
  localparam logic [7:0] M0 = 8'h41;
  localparam logic [7:0] M1 = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_mark = 0, cfg_ebcdic = 0;
  logic [7:0] rx_data = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic cmd_unlock = 0, cmd_lock = 0, lost_ack = 0;
  logic fifo_wr, locked, lost_pulse, ctrl_irq, match_irq;
  logic [7:0] fifo_data;

  int checks = 0, failures = 0;
  bit mL, mP, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_gate i_rx_addr_gate (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_mark(rx_mark),
    .cfg_mode(cfg_mode), .cfg_ebcdic(cfg_ebcdic), .cfg_station(ST),
    .cfg_match0(M0), .cfg_match1(M1), .cmd_unlock(cmd_unlock), .cmd_lock(cmd_lock),
    .lost_ack(lost_ack), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .locked(locked),
    .lost_pulse(lost_pulse), .ctrl_irq(ctrl_irq), .match_irq(match_irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_ctrl(bit [7:0] d, bit ebc);
    if (ebc) return d < 64;
    return (d < 32) || (d == 127);
  endfunction

  // Called at a negedge: drive, compute model, wait one edge, sample at next negedge.
  task automatic step(bit v, bit [7:0] d, bit m, bit ul, bit lk, bit ack);
    int md = int'(cfg_mode);
    bit cmd = ul | lk;
    bit hit = v && m && ((md == 2 && d == ST) || md == 1);
    bit self_open = hit && !cmd;
    bit wr = v && (!mL || self_open);
    bit discard = v && !wr;
    bit lost = discard && mP && !ack;
    bit ctl = v && md == 3 && is_ctrl(d, cfg_ebcdic);
    bit mt = v && (d == M0 || d == M1);
    bit nL = lk ? 1'b1 : ul ? 1'b0 : self_open ? 1'b0 : mL;
    string ltag;
    if (cmd && hit) ltag = "R9";
    else if (cmd) ltag = "R3";
    else if (md == 2) ltag = "R4";
    else if (md == 1) ltag = "R5";
    else if (md == 0) ltag = "R6";
    else ltag = "R7";
    rx_valid = v; rx_data = d; rx_mark = m;
    cmd_unlock = ul; cmd_lock = lk; lost_ack = ack;
    @(posedge clk);
    @(negedge clk);
    chk((cmd && hit) ? "R9" : "R2", int'(fifo_wr), int'(wr));
    if (wr) chk("R2", int'(fifo_data), int'(d));
    chk(ltag, int'(locked), int'(nL));
    chk((ack && discard) ? "R11" : "R10", int'(lost_pulse), int'(lost));
    chk("R7", int'(ctrl_irq), int'(ctl));
    chk("R8", int'(match_irq), int'(mt));
    mL = nL;
    mP = discard || (mP && !ack);
    rx_valid = 0; cmd_unlock = 0; cmd_lock = 0; lost_ack = 0; rx_mark = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(locked), 1);
    chk("R1", int'(fifo_wr), 0);
    chk("R1", int'(lost_pulse), 0);
    chk("R1", int'(ctrl_irq), 0);
    chk("R1", int'(match_irq), 0);
    mL = 1; mP = 0;

    for (int md = 0; md < 4; md++) begin
      for (int eb = 0; eb < 2; eb++) begin
        if (md != 3 && eb == 1) continue;
        cfg_mode = md[1:0];
        cfg_ebcdic = eb[0];
        for (int st = 0; st < 2; st++) begin
          for (int d = 0; d < 256; d++) begin
            for (int m = 0; m < 2; m++) begin
              step(0, 8'h00, 0, st == 0, st == 1, 1);
              step(1, d[7:0], m[0], 0, 0, 0);
            end
          end
        end
      end
    end

    // R9: commands beat a matching address in the same cycle
    cfg_mode = 2'b10;
    step(0, 0, 0, 0, 1, 1);
    step(1, ST, 1, 0, 1, 0);
    step(1, ST, 1, 1, 0, 1);
    step(0, 0, 0, 0, 1, 0);
    step(1, ST, 1, 1, 1, 1);
    cfg_mode = 2'b01;
    step(1, 8'h12, 1, 0, 1, 1);

    // R10 / R11: lost sequence in manual mode, locked
    cfg_mode = 2'b00;
    step(0, 0, 0, 0, 1, 1);
    step(1, 8'h10, 0, 0, 0, 0);
    step(1, 8'h11, 0, 0, 0, 0);
    step(1, 8'h12, 1, 0, 0, 1);
    step(1, 8'h13, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 8'h14, 0, 0, 0, 0);
    step(1, M1, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule